// File: doc/BRIEF.md
# Chainable Three-Wire Serial Word Loader

This block receives converter words over a three-wire serial link made of a shift clock, a data line and a latch line. All three lines are treated as asynchronous to the block's system clock. They are brought into that clock domain and edge-detected there. Each rising shift-clock edge moves one data bit into a 16-bit serial register, most significant bit first. A rising latch edge copies that register, all bits at once, into a holding register that feeds the converter core. The same cycle raises a one-cycle load strobe.

The bit that has reached the far end of the serial register is driven on a serial output. It is updated on each falling shift-clock edge, so a following device has a full half period of hold time. Devices can therefore be chained output-to-input. The host shifts 16 bits for each device in the chain, then gives one latch pulse, and every device commits its own word in the same cycle. Shifting never disturbs the holding register between latch edges.

Top module: `serial_word_loader`

## Requirements
- R1: While rst_n is low, word_out is 0, load_strobe is 0 and sdo_out is 0.
- R2: The data line is sampled once per rising shift-clock edge. After 16 such edges and a latch, word_out[15] holds the first bit sent and word_out[0] holds the last.
- R3: word_out changes only in a cycle where load_strobe is 1. Shift-clock activity and latch falling edges leave it unchanged.
- R4: Each rising latch edge produces exactly one load_strobe pulse, one system-clock cycle wide. word_out shows the new word in that same cycle. A falling latch edge produces no pulse.
- R5: sdo_out changes only after a falling shift-clock edge. It then takes the value of the most significant serial-register bit, which is the bit that leaves the register at the next rising shift-clock edge.
- R6: With two devices chained (the first device's sdo_out drives the second device's data input, and both share clock and latch), 32 shifted bits followed by one latch load the first 16 bits into the second device and the last 16 bits into the first device.
- R7: When a latch rising edge and a shift-clock rising edge are detected in the same system-clock cycle, the holding register takes the serial register's contents from before that shift, and the new bit is still shifted in.
- R8: When more than 16 bits are shifted before a latch, only the last 16 bits are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_in | input | 1 | Serial shift clock, asynchronous |
| sdi_in | input | 1 | Serial data input, asynchronous |
| latch_in | input | 1 | Latch line; its rising edge commits the word |
| sdo_out | output | 1 | Serial data output for chaining |
| word_out | output | WORD_W | Holding register driving the converter core |
| load_strobe | output | 1 | One-cycle pulse when word_out is loaded |

## Verification
A shift and a commit can fall in the same system-clock cycle. This happens when the shift clock and the latch line rise together, because both pass through the same synchronizer depth. The bench provokes this by raising both lines on the same clock phase. It checks that the committed word is the serial contents from before that shift, and that the bit taken in at that edge appears only in later words. A falling shift-clock edge arriving together with a latch edge is exercised as well. In that case the serial output must still advance while the holding register loads.

// File: rtl/serial_word_loader.sv
module serial_word_loader #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              sdi_in,
  input  logic              latch_in,
  output logic              sdo_out,
  output logic [WORD_W-1:0] word_out,
  output logic              load_strobe
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclk_s, sdi_s, latch_s;
  logic                   sclk_d, latch_d;
  logic [WORD_W-1:0]      shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_s  <= '0;
      sdi_s   <= '0;
      latch_s <= '0;
      sclk_d  <= 1'b0;
      latch_d <= 1'b0;
    end else begin
      sclk_s  <= {sclk_s[SYNC_STAGES-2:0], sclk_in};
      sdi_s   <= {sdi_s[SYNC_STAGES-2:0], sdi_in};
      latch_s <= {latch_s[SYNC_STAGES-2:0], latch_in};
      sclk_d  <= sclk_s[TOP];
      latch_d <= latch_s[TOP];
    end
  end

  wire sclk_rise  = sclk_s[TOP] & ~sclk_d;
  wire sclk_fall  = ~sclk_s[TOP] & sclk_d;
  wire latch_rise = latch_s[TOP] & ~latch_d;

  always_ff @(posedge clk) begin
    if (!rst_n)         shreg <= '0;
    else if (sclk_rise) shreg <= {shreg[WORD_W-2:0], sdi_s[TOP]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         sdo_out <= 1'b0;
    else if (sclk_fall) sdo_out <= shreg[WORD_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_out    <= '0;
      load_strobe <= 1'b0;
    end else begin
      load_strobe <= latch_rise;
      if (latch_rise) word_out <= shreg;
    end
  end

  a_r3_word_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_out) |-> load_strobe);

  a_r4_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |=> !load_strobe);

  a_r4_strobe_from_latch: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |-> $past(latch_rise));

  a_r5_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_out) |-> $past(sclk_fall));

  a_r2_shift_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shreg) |-> $past(sclk_rise));

  a_r7_commit_pre_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_rise && sclk_rise) |=> (word_out == $past(shreg)));

endmodule

// File: tb/tb_serial_word_loader.sv
module tb_serial_word_loader;
  localparam int W = 16;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, latch = 1'b0;
  logic sdo_a, sdo_b, stb_a, stb_b;
  logic [W-1:0] word_a, word_b;

  always #2 clk = ~clk;

  serial_word_loader #(.WORD_W(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .sdi_in(sdi), .latch_in(latch),
    .sdo_out(sdo_a), .word_out(word_a), .load_strobe(stb_a));

  serial_word_loader #(.WORD_W(W), .SYNC_STAGES(2)) dut_next (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .sdi_in(sdo_a), .latch_in(latch),
    .sdo_out(sdo_b), .word_out(word_b), .load_strobe(stb_b));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int strobe_cnt = 0, wide_cnt = 0;
  logic prev_stb = 1'b0;
  logic [W-1:0] word_at_strobe = '0;

  logic [W-1:0] m_sh_a = '0, m_sh_b = '0, m_word_a = '0, m_word_b = '0;
  logic m_sdo_a = 1'b0, m_sdo_b = 1'b0;

  always @(negedge clk) begin
    if (rst_n && stb_a) begin
      strobe_cnt++;
      word_at_strobe = word_a;
      if (prev_stb) wide_cnt++;
    end
    prev_stb = stb_a;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [W-1:0] shift_in(input logic [W-1:0] r, input logic b);
    return {r[W-2:0], b};
  endfunction

  task automatic rise(input logic b, input logic with_latch);
    int s0;
    s0 = strobe_cnt;
    @(negedge clk);
    sclk = 1'b1; sdi = b;
    if (with_latch) begin
      latch = 1'b1;
      m_word_a = m_sh_a;
      m_word_b = m_sh_b;
    end
    m_sh_b = shift_in(m_sh_b, m_sdo_a);
    m_sh_a = shift_in(m_sh_a, b);
    wait_n(HALF);
    chk("R5 sdo held across rise", {31'd0, sdo_a}, {31'd0, m_sdo_a});
    if (with_latch) begin
      chk("R7 commit takes pre-shift word", {16'd0, word_a}, {16'd0, m_word_a});
      chk("R7 single strobe", strobe_cnt - s0, 1);
    end else begin
      chk("R3 word unchanged by shift", {16'd0, word_a}, {16'd0, m_word_a});
    end
  endtask

  task automatic fall(input logic drop_latch);
    @(negedge clk);
    sclk = 1'b0;
    if (drop_latch) latch = 1'b0;
    m_sdo_a = m_sh_a[W-1];
    m_sdo_b = m_sh_b[W-1];
    wait_n(HALF);
    chk("R5 sdo after fall", {31'd0, sdo_a}, {31'd0, m_sdo_a});
  endtask

  task automatic send_bit(input logic b);
    rise(b, 1'b0);
    fall(1'b0);
  endtask

  task automatic pulse_latch(input string req);
    int s0;
    s0 = strobe_cnt;
    @(negedge clk);
    latch = 1'b1;
    m_word_a = m_sh_a;
    m_word_b = m_sh_b;
    wait_n(HALF);
    chk({req, " word"}, {16'd0, word_a}, {16'd0, m_word_a});
    chk("R4 one strobe per latch", strobe_cnt - s0, 1);
    chk("R4 word valid with strobe", {16'd0, word_at_strobe}, {16'd0, m_word_a});
    chk("R6 chained word", {16'd0, word_b}, {16'd0, m_word_b});
    @(negedge clk);
    latch = 1'b0;
    wait_n(HALF);
    chk("R4 no strobe on latch fall", strobe_cnt - s0, 1);
    chk("R3 word kept after latch fall", {16'd0, word_a}, {16'd0, m_word_a});
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    finish_run();
  end

  initial begin
    logic [W-1:0] w, w2;
    void'($urandom(32'h5eed_1234));
    wait_n(5);
    chk("R1 word in reset", {16'd0, word_a}, 0);
    chk("R1 strobe in reset", {31'd0, stb_a}, 0);
    chk("R1 sdo in reset", {31'd0, sdo_a}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_n(4);

    w = 16'hA5C3;
    for (int i = W - 1; i >= 0; i--) send_bit(w[i]);
    pulse_latch("R2 msb-first word");
    chk("R2 first bit in msb", {31'd0, word_a[W-1]}, {31'd0, w[W-1]});

    w = 16'h0001;
    for (int i = W - 1; i >= 0; i--) send_bit(w[i]);
    pulse_latch("R2 lsb only");

    for (int i = 0; i < 21; i++) send_bit(1'($urandom));
    pulse_latch("R8 overlong frame keeps last 16");

    w = 16'h1234; w2 = 16'hFEDC;
    for (int i = W - 1; i >= 0; i--) send_bit(w[i]);
    for (int i = W - 1; i >= 0; i--) send_bit(w2[i]);
    pulse_latch("R6 two-device frame");
    chk("R6 tail device holds first word", {16'd0, word_b}, {16'd0, w});
    chk("R6 head device holds last word", {16'd0, word_a}, {16'd0, w2});

    for (int i = 0; i < W; i++) send_bit(1'($urandom));
    rise(1'b1, 1'b1);
    fall(1'b1);
    wait_n(HALF);
    for (int i = 0; i < W - 1; i++) send_bit(1'($urandom));
    pulse_latch("R7 collided bit kept in stream");

    for (int i = 0; i < W; i++) send_bit(1'($urandom));
    rise(1'b0, 1'b0);
    @(negedge clk);
    sclk = 1'b0; latch = 1'b1;
    m_sdo_a = m_sh_a[W-1]; m_sdo_b = m_sh_b[W-1];
    m_word_a = m_sh_a; m_word_b = m_sh_b;
    wait_n(HALF);
    chk("R7 fall with latch sdo", {31'd0, sdo_a}, {31'd0, m_sdo_a});
    chk("R7 fall with latch word", {16'd0, word_a}, {16'd0, m_word_a});
    @(negedge clk);
    latch = 1'b0;
    wait_n(HALF);

    for (int k = 0; k < 16; k++) begin
      int n;
      n = W + int'($urandom_range(0, 12));
      for (int i = 0; i < n; i++) send_bit(1'($urandom));
      pulse_latch("R2 random word");
    end

    chk("R4 strobe never wider than one cycle", wide_cnt, 0);
    finish_run();
  end
endmodule